// File: doc/BRIEF.md
# Store/Recall Cycle Sequencer

This block orders the internal steps of the two transfers between a volatile array and its nonvolatile shadow copy. A store request erases the shadow and then programs it with the array contents. A recall request clears the array and then loads it from the shadow. Each step is signalled by its own strobe and lasts a parameter-set number of clock cycles.

While any transfer is running, or while power is not good, the host port is locked and an active-low busy line is held low. A power-good input models the supply comparator. Whenever it is low, the block latches a pending recall and waits. When power-good returns, a recall runs by itself. Its load step uses a separate, longer length. Requests that arrive while the block is not idle are dropped, not queued.

Top module: `nv_xfer_seq`

## Requirements
- R1: After reset the block is in the power-wait state: busy_no=0, host_dis_o=1, and all four strobes are 0.
- R2: In the power-wait state, once pwr_good_i is 1 at a clock edge, clear_o is high for CLR_CYC cycles. Then load_o is high for HW_LOAD_CYC cycles. Then the block is idle.
- R3: In idle with pwr_good_i=1, a store_req_i sampled at an edge makes erase_o high for ERASE_CYC cycles, starting from that edge. Then program_o is high for PROG_CYC cycles. Then the block is idle.
- R4: In idle with pwr_good_i=1, a recall_req_i alone makes clear_o high for CLR_CYC cycles. Then load_o is high for LOAD_CYC cycles. Then the block is idle.
- R5: Whenever the block is not idle, busy_no=0 and host_dis_o=1. In idle, busy_no=1 and host_dis_o=0.
- R6: At most one of erase_o, program_o, clear_o and load_o is high in any cycle. None of them is high in idle or in the power-wait state.
- R7: Store or recall requests sampled while a transfer runs, or while power is low, are ignored. The running transfer keeps its lengths, and the block stays idle afterwards with no request present.
- R8: A low pwr_good_i at any edge puts the block into the power-wait state from the next cycle, aborting any transfer. A recall of R2 length then follows when power returns.
- R9: When store_req_i and recall_req_i are both high in idle, the store runs.
- R10: During a recall, neither erase_o nor program_o is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply above threshold |
| store_req_i | input | 1 | Store request from command detector |
| recall_req_i | input | 1 | Recall request from command detector |
| busy_no | output | 1 | Busy, active low |
| host_dis_o | output | 1 | Host reads and writes disabled |
| erase_o | output | 1 | Shadow erase step |
| program_o | output | 1 | Shadow program step |
| clear_o | output | 1 | Array clear step |
| load_o | output | 1 | Array load from shadow step |

## Verification
The hardest case to reach is a supply loss in the middle of a particular step, at a particular cycle, followed by a recall on power return that must use the longer load length. The stimulus picks the transfer kind and the abort cycle from a seeded $urandom. It drops pwr_good_i right after sampling that cycle, holds it low for a random time while injecting requests, and then checks the whole automatic recall cycle by cycle. Requests are also injected at random during running transfers, to confirm that no phase length stretches and no request is queued.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_PWR = 3'd0,
    ST_IDLE     = 3'd1,
    ST_ERASE    = 3'd2,
    ST_PROGRAM  = 3'd3,
    ST_CLEAR    = 3'd4,
    ST_LOAD     = 3'd5
  } seq_state_e;
endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!done_o)   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/nv_recall_latch.sv
module nv_recall_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // reset counts as power-up: recall pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b1;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
  import nv_seq_pkg::*;
#(
  parameter int unsigned ERASE_CYC   = 6,
  parameter int unsigned PROG_CYC    = 10,
  parameter int unsigned CLR_CYC     = 4,
  parameter int unsigned LOAD_CYC    = 8,
  parameter int unsigned HW_LOAD_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic store_req_i,
  input  logic recall_req_i,
  output logic busy_no,
  output logic host_dis_o,
  output logic erase_o,
  output logic program_o,
  output logic clear_o,
  output logic load_o
);
  localparam int unsigned MAX_A   = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned MAX_B   = (CLR_CYC > LOAD_CYC) ? CLR_CYC : LOAD_CYC;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_LEN = (MAX_C > HW_LOAD_CYC) ? MAX_C : HW_LOAD_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] len;
  logic             tmr_done, pend;

  always_comb begin
    unique case (state_q)
      ST_ERASE:   len = CNT_W'(ERASE_CYC);
      ST_PROGRAM: len = CNT_W'(PROG_CYC);
      ST_CLEAR:   len = CNT_W'(CLR_CYC);
      ST_LOAD:    len = pend ? CNT_W'(HW_LOAD_CYC) : CNT_W'(LOAD_CYC);
      default:    len = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_PWR: state_d = ST_CLEAR;           // power-good checked below
      ST_IDLE: begin
        if (store_req_i)       state_d = ST_ERASE; // store wins a tie
        else if (recall_req_i) state_d = ST_CLEAR;
      end
      ST_ERASE:   if (tmr_done) state_d = ST_PROGRAM;
      ST_PROGRAM: if (tmr_done) state_d = ST_IDLE;
      ST_CLEAR:   if (tmr_done) state_d = ST_LOAD;
      ST_LOAD:    if (tmr_done) state_d = ST_IDLE;
      default:    state_d = ST_WAIT_PWR;
    endcase
    if (!pwr_good_i) state_d = ST_WAIT_PWR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT_PWR;
    else         state_q <= state_d;
  end

  nv_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (state_d != state_q),
    .len_i     (len),
    .done_o    (tmr_done)
  );

  nv_recall_latch u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (!pwr_good_i),
    .clr_i  (state_q == ST_LOAD && tmr_done),
    .pend_o (pend)
  );

  assign busy_no    = (state_q == ST_IDLE);
  assign host_dis_o = (state_q != ST_IDLE);
  assign erase_o    = (state_q == ST_ERASE);
  assign program_o  = (state_q == ST_PROGRAM);
  assign clear_o    = (state_q == ST_CLEAR);
  assign load_o     = (state_q == ST_LOAD);
endmodule

// File: rtl/nv_xfer_seq_chk.sv
module nv_xfer_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic store_req_i,
  input logic recall_req_i,
  input logic busy_no,
  input logic host_dis_o,
  input logic erase_o,
  input logic program_o,
  input logic clear_o,
  input logic load_o
);
  logic any_stb;
  assign any_stb = erase_o | program_o | clear_o | load_o;

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, program_o, clear_o, load_o}));

  p_strobe_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> (!busy_no && host_dis_o));

  p_pwr_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (!busy_no && !any_stb));

  p_wait_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_no && !any_stb && pwr_good_i) |=> clear_o);

  p_idle_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_no && store_req_i && pwr_good_i) |=> erase_o);

  p_erase_then_prog_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(erase_o) && !erase_o && $past(pwr_good_i)) |-> program_o);

  p_clear_then_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clear_o) && !clear_o && $past(pwr_good_i)) |-> load_o);

  p_recall_no_nv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o || load_o) |=> (!erase_o && !program_o));
endmodule

bind nv_xfer_seq nv_xfer_seq_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwr_good_i   (pwr_good_i),
  .store_req_i  (store_req_i),
  .recall_req_i (recall_req_i),
  .busy_no      (busy_no),
  .host_dis_o   (host_dis_o),
  .erase_o      (erase_o),
  .program_o    (program_o),
  .clear_o      (clear_o),
  .load_o       (load_o)
);

// File: tb/nv_xfer_seq_tb_top.sv
module nv_xfer_seq_tb_top;
  localparam int E = 6, P = 10, C = 4, L = 8, H = 12;
  localparam int K_STORE = 0, K_RECALL = 1, K_HW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0, pwr_good_i = 1'b0;
  logic store_req_i = 1'b0, recall_req_i = 1'b0;
  logic busy_no, host_dis_o, erase_o, program_o, clear_o, load_o;
  int checks = 0, errors = 0;
  int unsigned seed_v;

  always #2 clk_i = ~clk_i;

  nv_xfer_seq #(.ERASE_CYC(E), .PROG_CYC(P), .CLR_CYC(C), .LOAD_CYC(L), .HW_LOAD_CYC(H)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_good_i(pwr_good_i),
    .store_req_i(store_req_i), .recall_req_i(recall_req_i),
    .busy_no(busy_no), .host_dis_o(host_dis_o), .erase_o(erase_o),
    .program_o(program_o), .clear_o(clear_o), .load_o(load_o));

  // 0 idle, 1 erase, 2 program, 3 clear, 4 load, 5 power-wait, 9 illegal
  function automatic int phase_code();
    int n = int'(erase_o) + int'(program_o) + int'(clear_o) + int'(load_o);
    if (n > 1 || busy_no == host_dis_o) return 9;
    if (busy_no) return (n == 0) ? 0 : 9;
    if (erase_o) return 1;
    if (program_o) return 2;
    if (clear_o) return 3;
    if (load_o) return 4;
    return 5;
  endfunction

  function automatic int total_len(int kind);
    if (kind == K_STORE) return E + P;
    if (kind == K_RECALL) return C + L;
    return C + H;
  endfunction

  function automatic int exp_phase(int kind, int t);
    if (kind == K_STORE) return (t < E) ? 1 : (t < E + P) ? 2 : 0;
    if (t < C) return 3;
    return (t < total_len(kind)) ? 4 : 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_noise(bit noise);
    store_req_i  = noise ? 1'($urandom_range(1)) : 1'b0;
    recall_req_i = noise ? 1'($urandom_range(1)) : 1'b0;
  endtask

  // request already driven at the last negedge; checks up to cut (or whole cycle)
  task automatic run_seq(int kind, string req, bit noise, int cut);
    int last = (cut < 0) ? total_len(kind) : cut;
    for (int t = 0; t <= last; t++) begin
      @(negedge clk_i);
      chk(phase_code() == exp_phase(kind, t), req, phase_code(), exp_phase(kind, t));
      drive_noise(noise && t < last);
    end
  endtask

  task automatic power_cycle(int low_cyc, string req);
    pwr_good_i = 1'b0;
    for (int i = 0; i < low_cyc; i++) begin
      @(negedge clk_i);
      chk(phase_code() == 5, req, phase_code(), 5);
      drive_noise(1'b1);
    end
    drive_noise(1'b0);
    pwr_good_i = 1'b1;
    run_seq(K_HW, req, 1'b0, -1);
  endtask

  task automatic request(int kind, bit both);
    store_req_i  = (kind == K_STORE);
    recall_req_i = (kind == K_RECALL) || both;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd1234);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk(phase_code() == 5, "R1", phase_code(), 5);
    // R7: requests while power is low are ignored
    power_cycle(4, "R7");
    @(negedge clk_i); request(K_STORE, 1'b0);
    run_seq(K_STORE, "R3", 1'b0, -1);
    request(K_RECALL, 1'b0);
    run_seq(K_RECALL, "R4", 1'b0, -1);
    request(K_STORE, 1'b1);
    run_seq(K_STORE, "R9", 1'b0, -1);
    // R10: recall phases never show erase/program (phase code compare)
    request(K_RECALL, 1'b0);
    run_seq(K_RECALL, "R10", 1'b1, -1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk(phase_code() == 0, "R7", phase_code(), 0);
    end
    // R8 directed: drop in first cycle of erase
    request(K_STORE, 1'b0);
    run_seq(K_STORE, "R8", 1'b0, 0);
    power_cycle(2, "R8");
    for (int it = 0; it < 60; it++) begin
      int kind = $urandom_range(1);
      int cut  = $urandom_range(total_len(kind) - 1);
      request(kind, $urandom_range(1) == 1);
      if ($urandom_range(2) == 0) begin
        run_seq(kind, "R8", 1'b1, cut);
        power_cycle(1 + $urandom_range(4), "R8");
      end else begin
        run_seq(kind, (kind == K_STORE) ? "R3" : "R7", 1'b1, -1);
      end
    end
    @(negedge clk_i);
    chk(busy_no == 1'b1 && host_dis_o == 1'b0, "R5", int'(busy_no), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule